// File: doc/BRIEF.md
# Deferred Invalidation Queue with Read-Barrier Drain

This block sits between the coherence interconnect and one core's private cache. It takes line-invalidate messages from the interconnect and acknowledges each one as soon as a slot holds it. The valid bits in the tag array are cleared later, one line per cycle, whenever the tag port is not claimed by a core access. Core loads never look inside the queue. A load to a line whose invalidation is still waiting therefore hits the old cached copy.

A read barrier closes that window. While the core holds a barrier request high, the block counts down the entries that were already queued when the request was captured. It pulses done once the last of those entries has been presented to the tag array. Messages that arrive during the drain are accepted and acknowledged as usual, and the barrier does not wait for them.

Top module: `inval_queue`

## Requirements
- R1: A message on `msg_valid` is taken at a clock edge where `msg_valid` is high, a slot is free and `msg_ack` is low. `msg_ack` is high for exactly the one cycle after that edge. The sender holds `msg_valid`/`msg_line` until it sees `msg_ack`.
- R2: While `DEPTH` (default 8) taken messages are still waiting, no new message is acknowledged. Acknowledgement resumes once an entry has been presented to the tag array.
- R3: Invalidations are presented on `inv_valid`/`inv_line` in the order the messages were acknowledged. At most one is presented per cycle.
- R4: `inv_valid` is high in a cycle only if `tag_busy` was low in the preceding cycle.
- R5: Every presented invalidation belongs to a message that was already acknowledged in an earlier cycle.
- R6: The block has no lookup path. A line stays valid in the tag array while its acknowledged invalidation is still queued, for as long as `tag_busy` holds the port.
- R7: With `bar_req` held high, `bar_done` pulses for one cycle only after every entry queued at the capture edge has been presented. It stays low while any of those entries is still blocked by `tag_busy`.
- R8: Messages arriving during a barrier drain are acknowledged normally. `bar_done` does not wait for them.
- R9: A barrier raised on an empty queue sees `bar_done` in the second cycle after `bar_req` rises.
- R10: An invalidate for a line that is not valid in the cache is queued and presented like any other, with no effect on other lines.
- R11: After reset, `msg_ack`, `inv_valid` and `bar_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Invalidate message present from interconnect |
| msg_line | input | LINE_W | Line address of the message |
| msg_ack | output | 1 | One-cycle acknowledge of a taken message |
| tag_busy | input | 1 | Tag port claimed by a core access; no invalidate next cycle |
| inv_valid | output | 1 | Clear the valid bit of `inv_line` this cycle |
| inv_line | output | LINE_W | Line address to invalidate |
| bar_req | input | 1 | Read-barrier request, held until `bar_done` |
| bar_done | output | 1 | One-cycle barrier completion pulse |

## Verification
The in-RTL assertions cover the cycle-level rules on every cycle. These are the one-cycle acknowledge that follows a held message, the absence of invalidates right after a busy cycle, the occupancy bound, and the one-cycle done pulse that answers a standing request. Only the bench scenarios can show ordering and drain semantics. These include arrival order across a full queue, the withheld acknowledge at capacity, the stale line that stays valid while invalidations wait, and a barrier that finishes ahead of later arrivals but never ahead of earlier ones.

// File: rtl/iq_pkg.sv
package iq_pkg;
  // Advance a circular pointer over 0..depth-1
  function automatic int unsigned ptr_step(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/iq_store.sv
module iq_store #(
  parameter int LINE_W = 8,
  parameter int DEPTH  = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [LINE_W-1:0] push_line,
  input  logic              port_busy,
  output logic              pop,
  output logic              full,
  output logic [CW-1:0]     level,
  output logic              out_valid,
  output logic [LINE_W-1:0] out_line
);
  import iq_pkg::*;

  logic [LINE_W-1:0] slots [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;

  assign full = (level == CW'(DEPTH));
  assign pop  = (level != '0) && !port_busy;

  // storage written without reset so it can map to block RAM
  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_line;
    if (pop)  out_line      <= slots[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      level     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= pop;
      if (push) wr_ptr <= PW'(ptr_step(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PW'(ptr_step(int'(rd_ptr), DEPTH));
      level <= level + CW'(push) - CW'(pop);
    end
  end

  a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));
  a_r4_idle_after_busy: assert property (@(posedge clk) disable iff (rst)
    port_busy |=> !out_valid);
endmodule

// File: rtl/iq_accept.sv
module iq_accept (
  input  logic clk,
  input  logic rst,
  input  logic msg_valid,
  input  logic full,
  output logic push,
  output logic msg_ack
);
  assign push = msg_valid && !full && !msg_ack;

  always_ff @(posedge clk) begin
    if (rst) msg_ack <= 1'b0;
    else     msg_ack <= push;
  end

  a_r1_ack_follows_msg: assert property (@(posedge clk) disable iff (rst)
    msg_ack |-> $past(msg_valid));
  a_r1_ack_single: assert property (@(posedge clk) disable iff (rst)
    msg_ack |=> !msg_ack);
  a_r2_no_ack_when_full: assert property (@(posedge clk) disable iff (rst)
    (full && !$past(msg_ack)) |=> !msg_ack);
endmodule

// File: rtl/iq_barrier.sv
module iq_barrier #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bar_req,
  input  logic          pop,
  input  logic [CW-1:0] level,
  output logic          bar_done
);
  logic          draining;
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      draining <= 1'b0;
      left     <= '0;
      bar_done <= 1'b0;
    end else begin
      bar_done <= 1'b0;
      if (!draining) begin
        if (bar_req && !bar_done) begin
          draining <= 1'b1;
          left     <= level - CW'(pop);
        end
      end else if (left == '0) begin
        bar_done <= 1'b1;
        draining <= 1'b0;
      end else if (pop) begin
        left <= left - 1'b1;
      end
    end
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    bar_done |=> !bar_done);
  a_r7_done_needs_req: assert property (@(posedge clk) disable iff (rst)
    bar_done |-> $past(bar_req));
endmodule

// File: rtl/inval_queue.sv
module inval_queue #(
  parameter int LINE_W = 8,
  parameter int DEPTH  = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_valid,
  input  logic [LINE_W-1:0] msg_line,
  output logic              msg_ack,
  input  logic              tag_busy,
  output logic              inv_valid,
  output logic [LINE_W-1:0] inv_line,
  input  logic              bar_req,
  output logic              bar_done
);
  logic          push, pop, full;
  logic [CW-1:0] level;

  iq_accept u_accept (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .full(full),
    .push(push), .msg_ack(msg_ack)
  );

  iq_store #(.LINE_W(LINE_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .push(push), .push_line(msg_line),
    .port_busy(tag_busy), .pop(pop), .full(full), .level(level),
    .out_valid(inv_valid), .out_line(inv_line)
  );

  iq_barrier #(.DEPTH(DEPTH)) u_barrier (
    .clk(clk), .rst(rst), .bar_req(bar_req), .pop(pop), .level(level),
    .bar_done(bar_done)
  );

  a_r4_port_respected: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> !$past(tag_busy));
  a_r11_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!msg_ack && !inv_valid && !bar_done));
endmodule

// File: tb/inval_queue_tb.sv
module inval_queue_tb;
  localparam int LW = 8;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic msg_valid = 1'b0, tag_busy = 1'b0, bar_req = 1'b0;
  logic [LW-1:0] msg_line = '0;
  logic msg_ack, inv_valid, bar_done;
  logic [LW-1:0] inv_line;

  int errors = 0, checks = 0, issued = 0;
  logic [LW-1:0] exp_q[$];
  logic [255:0] vbits = '0;
  logic last_busy = 1'b0;

  always #5 clk = ~clk;

  inval_queue #(.LINE_W(LW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_line(msg_line),
    .msg_ack(msg_ack), .tag_busy(tag_busy), .inv_valid(inv_valid),
    .inv_line(inv_line), .bar_req(bar_req), .bar_done(bar_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) last_busy = tag_busy;

  // monitor: pops expected lines as invalidates appear
  always @(negedge clk) begin
    if (!rst && inv_valid) begin
      check(!last_busy, "R4 invalidate after busy cycle", int'(last_busy), 0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 invalidate without prior ack", int'(inv_line), -1);
      end else begin
        logic [LW-1:0] e;
        e = exp_q.pop_front();
        check(inv_line == e, "R3 arrival order", int'(inv_line), int'(e));
      end
      vbits[inv_line] = 1'b0;
      issued++;
    end
  end

  // driver: returns cycles waited for ack
  task automatic send(input logic [LW-1:0] a, input int limit, output int waited);
    @(negedge clk);
    msg_valid = 1'b1; msg_line = a;
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!msg_ack && waited < limit);
    if (msg_ack) begin
      exp_q.push_back(a);
      msg_valid = 1'b0;
    end
  endtask

  task automatic drain_wait();
    int n = 0;
    while (exp_q.size() != 0 && n < 200) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int w;
    repeat (3) @(negedge clk);
    check(!msg_ack && !inv_valid && !bar_done, "R11 reset outputs",
          int'({msg_ack, inv_valid, bar_done}), 0);
    rst = 1'b0;

    // fill while the tag port is held
    tag_busy = 1'b1;
    vbits[8'h11] = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      send(8'h10 + 8'(i), 20, w);
      check(w == 1, "R1 ack one cycle after message", w, 1);
    end
    check(vbits[8'h11] == 1'b1, "R6 stale line still valid", int'(vbits[8'h11]), 1);
    check(issued == 0, "R4 nothing issued while busy", issued, 0);

    // full: ninth message must wait
    send(8'h40, 10, w);
    check(!msg_ack && w == 10, "R2 no ack when full", w, 10);
    tag_busy = 1'b0;
    begin
      int n = 0;
      while (!msg_ack && n < 20) begin @(negedge clk); n++; end
      check(msg_ack, "R2 ack after space opens", int'(msg_ack), 1);
      if (msg_ack) begin exp_q.push_back(8'h40); msg_valid = 1'b0; end
    end
    drain_wait();
    check(issued == DEPTH + 1, "R3 all drained", issued, DEPTH + 1);
    check(vbits[8'h11] == 1'b0, "R6 line cleared once presented", int'(vbits[8'h11]), 0);

    // busy toggling during drain
    tag_busy = 1'b1;
    for (int i = 0; i < 4; i++) send(8'h60 + 8'(i), 20, w);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); tag_busy = (i % 3 == 0);
    end
    tag_busy = 1'b0;
    drain_wait();
    check(exp_q.size() == 0, "R3 drain with busy gaps", exp_q.size(), 0);

    // barrier over four entries, two more arrive during drain
    tag_busy = 1'b1;
    for (int i = 0; i < 4; i++) send(8'h80 + 8'(i), 20, w);
    begin
      int base, got;
      base = issued;
      @(negedge clk); bar_req = 1'b1;
      repeat (8) @(negedge clk);
      check(!bar_done, "R7 no done while blocked", int'(bar_done), 0);
      send(8'h90, 20, w);
      check(w == 1, "R8 ack during drain", w, 1);
      send(8'h91, 20, w);
      check(w == 1, "R8 second ack during drain", w, 1);
      tag_busy = 1'b0;
      got = 0;
      for (int n = 0; n < 40 && !bar_done; n++) @(negedge clk);
      check(bar_done, "R7 done eventually", int'(bar_done), 1);
      got = issued - base;
      check(got >= 4 && got <= 5, "R7 R8 done after older entries only", got, 4);
      bar_req = 1'b0;
      @(negedge clk);
      check(!bar_done, "R7 done is one pulse", int'(bar_done), 0);
    end
    drain_wait();

    // barrier on empty queue
    @(negedge clk); bar_req = 1'b1;
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!bar_done && n < 10);
      check(n == 2, "R9 empty barrier latency", n, 2);
    end
    bar_req = 1'b0;
    repeat (2) @(negedge clk);

    // invalidate of a line not valid
    vbits[8'h05] = 1'b1;
    send(8'hA7, 20, w);
    drain_wait();
    check(vbits[8'hA7] == 1'b0 && vbits[8'h05] == 1'b1, "R10 no-op invalidate",
          int'(vbits[8'h05]), 1);
    check(exp_q.size() == 0, "R10 presented", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule